// File: doc/BRIEF.md
# Aligned Sub-Word Data Memory

This block is a small synchronous data store organised as 64-bit words and reached through byte addresses. A requester presents one request per cycle. The request carries a valid bit, a write select, a byte address, an access size code and write data. The size code selects 1, 2, 4 or 8 bytes. The upper address bits pick a word, and the three lowest bits pick the starting byte lane within that word.

Stores merge the new bytes into the stored word and leave all other lanes as they were. Loads return the selected lanes at their original position in the word, with every other lane forced to zero. The data is not shifted down to bit 0. A request whose start lane is not a multiple of its size is not carried out. Instead it produces an error response. Every accepted request receives a registered response exactly one cycle later.

Top module: `subword_mem`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid`, `rsp_err` and `rsp_rdata` are zero, and every word of storage reads back as zero.
- R2: The word index is the byte address shifted right by 3, and the start lane is the address AND 7. Requests to different word indices do not affect each other.
- R3: An access is legal only when (lane AND (bytes-1)) is 0. An illegal request responds with `rsp_err`=1, `rsp_rdata`=0 and `rsp_valid`=1 for one cycle.
- R4: An illegal store leaves every storage byte unchanged.
- R5: A legal store of N bytes writes the low N bytes of `req_wdata` into lanes lane..lane+N-1, in the same bit positions shifted up by lane*8. Write-data bits above N bytes are ignored, and all other lanes of the word keep their value.
- R6: A legal narrow load returns the stored word ANDed with a mask of ones over lanes lane..lane+N-1. The result is not shifted.
- R7: Size code 3 (8 bytes, lane 0) reads or writes the whole 64-bit word.
- R8: Size codes are 0=1, 1=2, 2=4 and 3=8 bytes. `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. In a cycle after an idle request, all response outputs are zero.
- R9: A store response has `rsp_rdata`=0, and `rsp_err`=0 when the store is legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Access size code, bytes = 1 << code |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Masked load data in place, zero otherwise |
| rsp_err | output | 1 | Previous request was misaligned |

## Verification
On every cycle, the assertions check the following:
- the one-cycle response timing and the idle response;
- that an error response carries no data and that store responses carry none;
- that a write changes nothing outside its lanes and writes its lanes exactly;
- that storage stays still when no legal store occurs.

Only the bench's scenarios can show that the returned lanes match what earlier stores left behind, including misaligned stores that were blocked. They also show that words at different indices stay independent and that the size-to-mask decode is right for every lane and size.

// File: rtl/smem_pkg.sv
// Shared constants and types for the sub-word data memory.
// Assumes little-endian lane numbering: lane 0 holds bits 7:0.
package smem_pkg;
    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned WORD_BITS  = WORD_BYTES * 8;
    localparam int unsigned LANE_W     = $clog2(WORD_BYTES);
    localparam int unsigned SIZE_W     = $clog2(LANE_W + 1);

    typedef logic [WORD_BITS-1:0]  word_t;
    typedef logic [WORD_BYTES-1:0] lanes_t;
endpackage

// File: rtl/smem_lane_decode.sv
// Lane decoder: turns a start lane and a size code into a legality flag,
// a bit mask over the selected lanes and the store data moved into place.
// Assumes the size code never exceeds log2 of the word width in bytes.
module smem_lane_decode
    import smem_pkg::*;
(
    input  logic [LANE_W-1:0] lane_ofs,
    input  logic [SIZE_W-1:0] size_code,
    input  word_t             wdata_in,
    output logic              aligned,
    output word_t             bit_mask,
    output word_t             wdata_placed
);
    logic [LANE_W:0] span_bytes;
    lanes_t          lane_en;

    // Purpose: count the bytes and check that the start lane is a multiple of them.
    always_comb begin
        span_bytes = (LANE_W+1)'(1) << size_code;
        aligned    = (({1'b0, lane_ofs} & (span_bytes - (LANE_W+1)'(1))) == '0);
    end

    // Purpose: enable the lanes from the start lane up to start + span - 1.
    always_comb begin
        for (int i = 0; i < int'(WORD_BYTES); i++) begin
            lane_en[i] = (i >= int'(lane_ofs)) && (i < int'(lane_ofs) + int'(span_bytes));
        end
    end

    // Expand each lane enable into eight mask bits.
    for (genvar g = 0; g < int'(WORD_BYTES); g++) begin : g_lane
        assign bit_mask[g*8 +: 8] = {8{lane_en[g]}};
    end

    // Purpose: shift right-justified store data up to its start lane.
    always_comb begin
        wdata_placed = wdata_in << {lane_ofs, 3'b000};
    end
endmodule

// File: rtl/smem_store.sv
// Word storage with a masked read-modify-write port and an asynchronous read port.
// Assumes DEPTH is a power of two; all words clear on synchronous reset.
module smem_store
    import smem_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_mask,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            rd_word
);
    logic [DEPTH-1:0][WORD_BITS-1:0] mem_q;

    // Purpose: clear on reset, otherwise merge the masked data into one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= (mem_q[wr_idx] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    // Purpose: present the addressed word for load masking.
    always_comb begin
        rd_word = mem_q[rd_idx];
    end

    // Storage must hold still unless a legal store is issued.
    assert_quiet_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem_q));

    // Lanes outside the mask keep their value across a write.
    assert_outside_lanes_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(wr_idx)] & ~$past(wr_mask)) ==
                   ($past(mem_q[wr_idx]) & ~$past(wr_mask))));

    // Lanes inside the mask take the new data.
    assert_inside_lanes_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mem_q[$past(wr_idx)] & $past(wr_mask)) ==
                   ($past(wr_data) & $past(wr_mask))));
endmodule

// File: rtl/subword_mem.sv
// Top level of the sub-word data memory: splits the byte address, rejects
// misaligned requests, performs masked stores and registers the response.
// Assumes at most one request per cycle and no back-pressure on the response.
module subword_mem
    import smem_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = IDX_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err
);
    logic [LANE_W-1:0] lane_ofs;
    logic [IDX_W-1:0]  word_idx;
    logic              aligned;
    word_t             bit_mask;
    word_t             wdata_placed;
    word_t             rd_word;
    logic              do_write;

    // Purpose: split the byte address into word index and start lane.
    always_comb begin
        lane_ofs = req_addr[LANE_W-1:0];
        word_idx = req_addr[ADDR_W-1:LANE_W];
        do_write = req_valid && req_write && aligned;
    end

    smem_lane_decode u_decode (
        .lane_ofs     (lane_ofs),
        .size_code    (req_size),
        .wdata_in     (req_wdata),
        .aligned      (aligned),
        .bit_mask     (bit_mask),
        .wdata_placed (wdata_placed)
    );

    smem_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_write),
        .wr_idx  (word_idx),
        .wr_mask (bit_mask),
        .wr_data (wdata_placed),
        .rd_idx  (word_idx),
        .rd_word (rd_word)
    );

    // Purpose: register valid, error and masked in-place load data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !aligned;
            rsp_rdata <= (req_valid && !req_write && aligned) ? (rd_word & bit_mask) : '0;
        end
    end

    // An error response is always a valid response with no data.
    assert_err_carries_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // Every request is answered in the next cycle.
    assert_reply_next_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // An idle cycle yields an all-zero response.
    assert_idle_reply_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));

    // Store replies never return data.
    assert_store_reply_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: tb/subword_mem_test.sv
// Bench: a behavioural reference memory, updated per request and compared every clock.
module subword_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int ADDR_W     = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic [63:0]       req_wdata;
    logic              rsp_valid;
    logic [63:0]       rsp_rdata;
    logic              rsp_err;

    logic [63:0] ref_mem [DEPTH];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    subword_mem #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic ev, logic ee, logic [63:0] ed);
        n_cmp++;
        if (rsp_valid !== ev || rsp_err !== ee || rsp_rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: actual v=%b e=%b d=%h expected v=%b e=%b d=%h",
                     tag, rsp_valid, rsp_err, rsp_rdata, ev, ee, ed);
        end
    endtask

    // Drive one request at a falling edge, update the model, compare at the next falling edge.
    task automatic do_req(string tag, bit v, bit w, int a, int s, logic [63:0] d);
        int off = a & 7;
        int nb = 1 << s;
        int idx = (a >> 3) % DEPTH;
        bit ok = (off % nb) == 0;
        logic [63:0] mask = '0;
        logic ev = v;
        logic ee = v && !ok;
        logic [63:0] ed = '0;
        for (int i = 0; i < nb; i++) begin
            if (off + i < 8) mask[(off+i)*8 +: 8] = 8'hff;
        end
        if (v && ok) begin
            if (!w) ed = ref_mem[idx] & mask;
            else ref_mem[idx] = (ref_mem[idx] & ~mask) | ((d << (off*8)) & mask);
        end
        req_valid = v;
        req_write = w;
        req_addr  = a[ADDR_W-1:0];
        req_size  = s[1:0];
        req_wdata = d;
        @(negedge clk);
        check(tag, ev, ee, ed);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R8: watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        rst_n = 1'b0;
        req_valid = 0; req_write = 0; req_addr = '0; req_size = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1", 0, 0, '0);
        rst_n = 1'b1;
        // R1: every word reads zero after reset
        for (int i = 0; i < DEPTH; i++) do_req("R1", 1, 0, i*8, 3, '0);
        // R7: whole-word store and load
        do_req("R7", 1, 1, 'h00, 3, 64'h8877_6655_4433_2211);
        do_req("R7", 1, 0, 'h00, 3, '0);
        // R6: each byte lane read in place
        for (int i = 0; i < 8; i++) do_req("R6", 1, 0, i, 0, '0);
        do_req("R6", 1, 0, 'h02, 1, '0);
        do_req("R6", 1, 0, 'h04, 2, '0);
        // R5: byte store with junk upper data, then whole-word view
        do_req("R5", 1, 1, 'h03, 0, 64'hdead_beef_cafe_00a5);
        do_req("R5", 1, 0, 'h00, 3, '0);
        do_req("R5", 1, 1, 'h0c, 2, 64'hffff_ffff_1234_5678);
        do_req("R5", 1, 0, 'h08, 3, '0);
        // R3: misaligned loads
        do_req("R3", 1, 0, 'h06, 2, '0);
        do_req("R3", 1, 0, 'h01, 1, '0);
        do_req("R3", 1, 0, 'h04, 3, '0);
        // R4: misaligned stores leave memory untouched
        do_req("R4", 1, 1, 'h13, 1, 64'hffff);
        do_req("R4", 1, 1, 'h02, 2, 64'hffff_ffff);
        do_req("R4", 1, 0, 'h00, 3, '0);
        do_req("R4", 1, 0, 'h10, 3, '0);
        // R2: neighbouring words stay independent
        do_req("R2", 1, 1, 'h28, 3, 64'h0123_4567_89ab_cdef);
        do_req("R2", 1, 0, 'h20, 3, '0);
        do_req("R2", 1, 0, 'h30, 3, '0);
        do_req("R2", 1, 0, 'h2e, 1, '0);
        // R9: store responses carry no data
        do_req("R9", 1, 1, 'h40, 0, 64'h55);
        // R8: idle cycles and back-to-back traffic
        do_req("R8", 0, 0, 'h00, 3, '0);
        do_req("R8", 0, 1, 'h08, 3, 64'h1);
        do_req("R8", 1, 0, 'h08, 3, '0);
        for (int k = 0; k < 400; k++) begin
            do_req("R8", ($urandom % 4) != 0, $urandom % 2, int'($urandom % 128),
                   int'($urandom % 4), {$urandom, $urandom});
        end
        for (int i = 0; i < DEPTH; i++) do_req("R5", 1, 0, i*8, 3, '0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule